// File: doc/BRIEF.md
# Tile Local Routing Crossbar

This block is the combinational input routing of one logic tile. It works in two stages. The first stage fills 32 local tracks, arranged as 4 groups of 8. Each track takes one value from a wide vector of candidate signals, such as routing wires, global nets and neighbour outputs. The second stage connects each of the 32 LUT input pins (8 cells with 4 pins each) to one of the local tracks.

Every buffer in both stages is set by a 5-bit configuration field: an enable bit and a 4-bit select. Each destination has its own fixed list of 16 eligible inputs, so not every source can reach every track, and not every track can reach every pin.

A buffer that is not enabled drives a defined 0. An all-zero configuration therefore gives all-zero outputs, and no unknown value reaches the cells. The configuration is static and the block has no clock.

Top module: `tile_local_xbar`

## Requirements
- R1: Track t (t = 8*group + member) is configured by field t of `trk_cfg_i`: bit 5t is the enable and bits 5t+1..5t+4 are the select s. When enabled, `trk_o[t]` equals `src_i[(3*t + 4*s) mod 64]`.
- R2: A track whose enable bit is 0 outputs 0, whatever its select bits and the source values are.
- R3: With both configuration vectors all zero, every track and every pin output is 0, even when all sources are 1.
- R4: Pin q = 4*cell + pin is configured by field q of `pin_cfg_i`, with the same layout as R1. When enabled with select s, the pin is driven by the track with group {s[0], s[1]} (s[0] is the high bit) and member (2*(s/4) + s[1] + cell + pin) mod 8.
- R5: For input 0 of cell 0, selects 0 to 15 reach these tracks in this order: g0_0, g2_0, g1_1, g3_1, g0_2, g2_2, g1_3, g3_3, g0_4, g2_4, g1_5, g3_5, g0_6, g2_6, g1_7, g3_7.
- R6: A pin whose enable bit is 0 outputs 0, whatever its select bits and the track values are.
- R7: A pin sees the track after the first stage. A pin that selects a disabled track reads 0.
- R8: The 16 selects of one track reach 16 distinct sources. When a single source is 1, at most one select of a track passes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Candidate signals for the first stage |
| trk_cfg_i | input | 160 | Track buffer fields, 5 bits per track: enable in bit 0, select in bits 4:1 |
| pin_cfg_i | input | 160 | Pin buffer fields, 5 bits per pin, same layout as the track fields |
| trk_o | output | 32 | Local track values; bit index is 8*group + member |
| pin_o | output | 32 | LUT input pin values; bit index is 4*cell + pin |

## Verification
Within one cycle, a change on a source can pass through the first stage, and a pin selection can change in the second stage. A pin whose track has just changed source, or whose track has just been disabled, shows whether the two stages compose correctly.

The bench provokes this by redrawing the sources, every track field and every pin field together on each cycle. It then judges both output vectors against a behavioural model that applies the two stages in order. Directed sweeps pin down the fixed ordering for cell 0, pin 0, and the source aliasing of chosen tracks.

// File: rtl/tile_local_xbar.sv
module tile_local_xbar #(
  parameter int NGRP  = 4,
  parameter int GSZ   = 8,
  parameter int NCELL = 8,
  parameter int NIN   = 4,
  parameter int NSRC  = 64,
  parameter int SELW  = 4
) (
  input  logic [NSRC-1:0]              src_i,
  input  logic [NGRP*GSZ*(SELW+1)-1:0] trk_cfg_i,
  input  logic [NCELL*NIN*(SELW+1)-1:0] pin_cfg_i,
  output logic [NGRP*GSZ-1:0]          trk_o,
  output logic [NCELL*NIN-1:0]         pin_o
);
  localparam int NTRK  = NGRP * GSZ;
  localparam int NPIN  = NCELL * NIN;
  localparam int FLD   = SELW + 1;
  localparam int NCAND = 1 << SELW;

  function automatic int trk_src(input int t, input int s);
    return (3 * t + 4 * s) % NSRC;
  endfunction

  function automatic int pin_trk(input int q, input int s);
    int c, p, grp, mem;
    c   = q / NIN;
    p   = q % NIN;
    grp = ((s & 1) << 1) | ((s >> 1) & 1);
    mem = (2 * (s >> 2) + ((s >> 1) & 1) + c + p) % GSZ;
    return grp * GSZ + mem;
  endfunction

  for (genvar t = 0; t < NTRK; t++) begin : g_trk
    logic [NCAND-1:0] cand;
    logic [SELW-1:0]  sel;
    logic             en;
    assign en  = trk_cfg_i[t*FLD];
    assign sel = trk_cfg_i[t*FLD+1 +: SELW];
    for (genvar s = 0; s < NCAND; s++) begin : g_c
      assign cand[s] = src_i[trk_src(t, s)];
    end
    assign trk_o[t] = en & cand[sel];
  end

  for (genvar q = 0; q < NPIN; q++) begin : g_pin
    logic [NCAND-1:0] cand;
    logic [SELW-1:0]  sel;
    logic             en;
    assign en  = pin_cfg_i[q*FLD];
    assign sel = pin_cfg_i[q*FLD+1 +: SELW];
    for (genvar s = 0; s < NCAND; s++) begin : g_c
      assign cand[s] = trk_o[pin_trk(q, s)];
    end
    assign pin_o[q] = en & cand[sel];
  end

  always_comb begin
    for (int t = 0; t < NTRK; t++) begin
      if (!trk_cfg_i[t*FLD])
        AST_TRK_OFF_ZERO: assert (trk_o[t] == 1'b0) else $error("track %0d driven while off", t); // R2
      else
        AST_TRK_FOLLOWS_SRC: assert (trk_o[t] == src_i[trk_src(t, int'(trk_cfg_i[t*FLD+1 +: SELW]))]) else $error("track %0d wrong source", t); // R1
    end
  end

  always_comb begin
    for (int q = 0; q < NPIN; q++) begin
      if (!pin_cfg_i[q*FLD])
        AST_PIN_OFF_ZERO: assert (pin_o[q] == 1'b0) else $error("pin %0d driven while off", q); // R6
      else
        AST_PIN_FOLLOWS_TRK: assert (pin_o[q] == trk_o[pin_trk(q, int'(pin_cfg_i[q*FLD+1 +: SELW]))]) else $error("pin %0d wrong track", q); // R4
    end
  end
endmodule

// File: tb/sim_tile_local_xbar.sv
module sim_tile_local_xbar;
  localparam int NT = 32, NP = 32, NS = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NS-1:0]   src;
  logic [NT*5-1:0] tcfg;
  logic [NP*5-1:0] pcfg;
  logic [NT-1:0]   trk;
  logic [NP-1:0]   pin;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  tile_local_xbar u0 (.src_i(src), .trk_cfg_i(tcfg), .pin_cfg_i(pcfg), .trk_o(trk), .pin_o(pin));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_trk(input int t, input bit en, input int s);
    tcfg[t*5] = en;
    tcfg[t*5+1 +: 4] = s[3:0];
  endtask

  task automatic set_pin(input int q, input bit en, input int s);
    pcfg[q*5] = en;
    pcfg[q*5+1 +: 4] = s[3:0];
  endtask

  function automatic logic [NT-1:0] ref_trk(input logic [NS-1:0] sv, input logic [NT*5-1:0] cv);
    logic [NT-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      int s = int'(cv[t*5+1 +: 4]);
      if (cv[t*5]) r[t] = sv[(3*t + 4*s) % 64];
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] ref_pin(input logic [NT-1:0] tv, input logic [NP*5-1:0] cv);
    int order [4] = '{0, 2, 1, 3};
    logic [NP-1:0] r = '0;
    for (int q = 0; q < NP; q++) begin
      int s = int'(cv[q*5+1 +: 4]);
      int m = (2*(s/4) + (s%4)/2 + q/4 + q%4) % 8;
      if (cv[q*5]) r[q] = tv[order[s%4]*8 + m];
    end
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c0_list [16] = '{0, 16, 9, 25, 2, 18, 11, 27, 4, 20, 13, 29, 6, 22, 15, 31};
    src = '0; tcfg = '0; pcfg = '0;
    repeat (3) @(posedge clk);
    step();
    chk("R3 reset trk", 64'(trk), 64'h0);
    chk("R3 reset pin", 64'(pin), 64'h0);
    rst = 1'b0;

    @(posedge clk); src = '1;
    step();
    chk("R3 zero cfg trk", 64'(trk), 64'h0);
    chk("R3 zero cfg pin", 64'(pin), 64'h0);

    // R2: disabled tracks with nonzero selects stay low
    @(posedge clk);
    for (int t = 0; t < NT; t++) set_trk(t, 1'b0, (t % 15) + 1);
    step();
    chk("R2 track off", 64'(trk), 64'h0);

    // R5: one track high at a time, sweep select of cell 0 pin 0
    for (int t = 0; t < NT; t++) set_trk(t, 1'b1, 0);
    for (int s = 0; s < 16; s++) begin
      @(posedge clk);
      src = '0;
      src[(3*c0_list[s]) % 64] = 1'b1;
      set_pin(0, 1'b1, s);
      step();
      chk($sformatf("R5 order sel %0d", s), 64'(pin[0]), 64'h1);
      chk($sformatf("R1 one-hot track %0d", c0_list[s]), 64'(trk), 64'(32'h1 << c0_list[s]));
    end

    // R6: pin disabled while its track is high
    @(posedge clk); set_pin(0, 1'b0, 15);
    step();
    chk("R6 pin off", 64'(pin[0]), 64'h0);

    // R7: pin selects a disabled track
    @(posedge clk); src = '1; set_pin(0, 1'b1, 3); set_trk(25, 1'b0, 0);
    step();
    chk("R7 disabled track seen", 64'(pin[0]), 64'h0);
    @(posedge clk); set_trk(25, 1'b1, 0);
    step();
    chk("R7 enabled track seen", 64'(pin[0]), 64'h1);

    // R8: alias check on sample tracks
    for (int k = 0; k < 4; k++) begin
      int t = k * 9 + 1;
      for (int x = 0; x < NS; x++) begin
        int hits = 0;
        int expect_hits = 0;
        for (int s = 0; s < 16; s++) begin
          if ((3*t + 4*s) % 64 == x) expect_hits++;
          @(posedge clk); src = '0; src[x] = 1'b1; set_trk(t, 1'b1, s);
          step();
          if (trk[t]) hits++;
        end
        chk($sformatf("R8 track %0d src %0d", t, x), 64'(hits), 64'(expect_hits));
      end
    end

    // R1 R4: random concurrent changes on both stages
    for (int i = 0; i < 3000; i++) begin
      logic [NT-1:0] et;
      @(posedge clk);
      src = {$urandom, $urandom};
      for (int t = 0; t < NT; t++) set_trk(t, ($urandom % 4) != 0, int'($urandom % 16));
      for (int q = 0; q < NP; q++) set_pin(q, ($urandom % 4) != 0, int'($urandom % 16));
      step();
      et = ref_trk(src, tcfg);
      chk("R1 random trk", 64'(trk), 64'(et));
      chk("R4 random pin", 64'(pin), 64'(ref_pin(et, pcfg)));
    end
    summary();
  end
endmodule